// File: doc/BRIEF.md
# Serial Receive Port with Byte Queue and Sticky Status

This block is the receive half of an asynchronous serial port. It watches a single serial input line and, with a 16x oversampling tick, finds start bits and samples eight data bits (least significant first) and one stop bit. Each finished frame goes into a 16-entry byte queue. Software reaches the block through a small register bus. There it can turn reception on and off, pick a fill threshold, read sticky status flags, pop received bytes and read how many bytes are held.

The status flags are a threshold-reached flag, a quiet-line-with-leftover-data flag, a framing-error flag and a break flag. The interrupt output follows the threshold-reached flag. A flag can only be cleared by a two-step handshake: a status read that sees the flag set, then a status write with a 0 in that bit. A flag that rises again between the read and the write therefore cannot be lost. The status register also shows the current level of the input line, so software can tell a break from a plain framing error.

Inside the block, the frame sampler feeds the byte queue over a valid/ready pair. The serial line cannot be held back, so a byte offered while the queue reports not-ready is dropped. The pop side is driven by data-register reads, and a read of an empty queue pops nothing.

Top module: `serial_rx_port`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent least significant bit first, and 1 stop bit, each bit 16 ticks long. A start is taken when the line is low 8 ticks after the falling edge, and each later bit is sampled at its centre. Every completed frame is offered to the queue.
- R2: If the line is back high at the mid-start check, the start is rejected and no byte is stored.
- R3: Control register (address 0) bit 0 is the receive enable. While it is 0 the sampler is held idle and nothing is stored.
- R4: The queue holds 16 bytes. A read of address 2 returns the oldest byte and pops it. Address 3 returns the current byte count. A byte that arrives while the queue is full is discarded, and the count stays at 16.
- R5: Status (address 1) bit 0 is the threshold flag. It sets when the count goes from below the threshold to at or above it. Control bits 2:1 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R6: The output `rx_irq` is high exactly while the threshold flag is set.
- R7: Status bit 1 is the quiet flag. It sets when 240 ticks (1.5 frames) pass with no stop bit, provided the queue is not empty and holds fewer bytes than the threshold.
- R8: Status bit 2 is the framing-error flag. It sets when the stop bit is sampled low, and the byte is still stored.
- R9: Status bit 3 is the break flag. It sets when start, data and stop bits are all low. After any framing error the sampler waits for the line to go high before it looks for a new start, so a long break stores exactly one byte (0x00).
- R10: Status bit 4 reads the synchronised current line level. Writes to this bit are ignored.
- R11: A flag bit clears only when a status write carries 0 in that bit and an earlier status read saw that bit as 1. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R12: After reset, control reads 0x00, status reads 0x10 with the line idle high, count reads 0 and `rx_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 count |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rx_irq | output | 1 | Receive interrupt, follows the threshold flag |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the strobe, and the pop or arm side effect takes place at the next clock edge. A byte enters the queue at the stop-bit centre: two synchroniser stages, then eight ticks for the start and sixteen ticks for each later bit. The count changes one cycle after that, and the threshold flag and `rx_irq` follow one cycle later again. Each frame task therefore drives a further idle bit time before any check. The quiet flag is checked once just after a frame, where it must still be clear, and again after a wait longer than 240 ticks. A behavioural queue in the bench holds the expected bytes and count, and the bench compares it against count and data reads.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI
  } rx_state_e;

  localparam int FLG_RDF  = 0;
  localparam int FLG_DR   = 1;
  localparam int FLG_ER   = 2;
  localparam int FLG_BRK  = 3;
  localparam int NFLAGS   = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rx_in,
  output logic          frame_valid,
  output logic [DW-1:0] frame_data,
  output logic          frame_ferr,
  output logic          frame_brk,
  output logic          line_level
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] TOPB = BW'(DW - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end
  assign rx_s       = sync_q[1];
  assign line_level = rx_s;
  assign frame_data = sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      frame_valid <= 1'b0;
      frame_ferr  <= 1'b0;
      frame_brk   <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (!en) begin
        state_q <= S_IDLE;
      end else if (tick) begin
        case (state_q)
          S_IDLE: if (!rx_s) begin
            state_q <= S_START;
            cnt_q   <= '0;
          end
          S_START: begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= rx_s ? S_IDLE : S_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[DW-1:1]};
              if (bit_q == TOPB) state_q <= S_STOP;
              else               bit_q   <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q       <= '0;
              frame_valid <= 1'b1;
              frame_ferr  <= !rx_s;
              frame_brk   <= !rx_s && (sh_q == '0);
              state_q     <= rx_s ? S_IDLE : S_WAITHI;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_WAITHI: if (rx_s) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == S_IDLE);
  assert_push_from_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(state_q == S_STOP));
  assert_brk_wait_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_brk && en) |-> state_q == S_WAITHI);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_wr, do_rd;

  assign wr_ready = (lvl_q != FULL);
  assign rd_valid = (lvl_q != '0);
  assign do_wr    = wr_valid && wr_ready;
  assign do_rd    = rd_valid && rd_ready;
  assign rd_data  = mem[rp_q];
  assign level    = lvl_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rd_ready) |=> lvl_q == $past(lvl_q));
  assert_pop_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && rd_valid && !wr_valid) |=> lvl_q == $past(lvl_q) - 1'b1);
endmodule

// File: rtl/srx_flag.sv
module srx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic seen_rd,
  input  logic wr,
  input  logic wbit,
  output logic flag
);
  logic flag_q, arm_q, clr;

  assign clr  = wr && arm_q && !wbit;
  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set | (flag_q & ~clr);
      arm_q  <= clr ? 1'b0 : (arm_q | (seen_rd & flag_q));
    end
  end

  assert_clear_needs_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && wr && !wbit));
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import srx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          os_tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_irq
);
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int TO  = ((DW + 2) * OVS * 3) / 2;
  localparam int TOW = $clog2(TO + 1);
  localparam logic [TOW-1:0] TO_LAST = TOW'(TO - 1);
  localparam logic [TOW-1:0] TO_MAX  = TOW'(TO);

  logic          en_q;
  logic [1:0]    trig_q;
  logic [LW-1:0] trig_lvl, fifo_level;
  logic          fv, ferr, brk, line_lvl;
  logic [DW-1:0] fdata, rd_data;
  logic          wr_ready, rd_valid;
  logic          stat_rd, stat_wr, data_rd, ctrl_wr;
  logic          lvl_now, lvl_prev_q, quiet_evt;
  logic [TOW-1:0] idle_q;
  logic [NFLAGS-1:0] set_vec, flags;
  logic          unused_wbits;

  assign unused_wbits = ^bus_wdata[DW-1:NFLAGS];

  assign stat_rd = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign stat_wr = bus_sel &&  bus_wr && (bus_addr == A_STAT);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == A_DATA);
  assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= 2'b00;
    end else if (ctrl_wr) begin
      en_q   <= bus_wdata[0];
      trig_q <= bus_wdata[2:1];
    end
  end
  assign trig_lvl = LW'(trig_level(trig_q));

  srx_sampler #(.DW(DW), .OVS(OVS)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(os_tick), .rx_in(rx_line),
    .frame_valid(fv), .frame_data(fdata), .frame_ferr(ferr),
    .frame_brk(brk), .line_level(line_lvl)
  );

  srx_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(fv), .wr_ready(wr_ready), .wr_data(fdata),
    .rd_valid(rd_valid), .rd_ready(data_rd), .rd_data(rd_data),
    .level(fifo_level)
  );

  // quiet-line timer: counts ticks since the last stop bit
  always_ff @(posedge clk) begin
    if (!rst_n || !en_q || fv) idle_q <= '0;
    else if (os_tick && idle_q != TO_MAX) idle_q <= idle_q + 1'b1;
  end
  assign quiet_evt = en_q && os_tick && (idle_q == TO_LAST);

  assign lvl_now = (fifo_level >= trig_lvl);
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev_q <= 1'b0;
    else        lvl_prev_q <= lvl_now;
  end

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_RDF] = lvl_now && !lvl_prev_q;
    set_vec[FLG_DR]  = quiet_evt && rd_valid && !lvl_now;
    set_vec[FLG_ER]  = fv && ferr;
    set_vec[FLG_BRK] = fv && brk;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    srx_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_vec[g]), .seen_rd(stat_rd),
      .wr(stat_wr), .wbit(bus_wdata[g]), .flag(flags[g])
    );
  end

  assign rx_irq = flags[FLG_RDF];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[2:0] = {trig_q, en_q};
      A_STAT: bus_rdata[NFLAGS:0] = {line_lvl, flags};
      A_DATA: bus_rdata = rd_valid ? rd_data : '0;
      default: bus_rdata[LW-1:0] = fifo_level;
    endcase
  end

  assert_rdf_at_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_RDF]) |-> $past(fifo_level >= trig_lvl));
  assert_dr_below_threshold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_DR]) |-> $past(fifo_level != '0 && fifo_level < trig_lvl));
  assert_er_with_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_ER]) |-> $past(fv));
endmodule

// File: tb/serial_rx_port_test.sv
module serial_rx_port_test;
  localparam int BITCLK = 32;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2, AN = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       rx_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model_q[$];
  bit model_en = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  serial_rx_port uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(b[i]);
    bit_time(stop);
    bit_time(1'b1);
    if (model_en && model_q.size() < 16) model_q.push_back(b);
  endtask

  task automatic check_count(input string req);
    logic [7:0] d;
    rd(AN, d);
    check(req, d, 8'(model_q.size()));
  endtask

  task automatic pop_check(input string req);
    logic [7:0] d;
    rd(AD, d);
    check(req, d, model_q.pop_front());
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12: reset values
    rd(AC, d); check("R12 ctrl", d, 8'h00);
    rd(AS, d); check("R12 status", d, 8'h10);
    check_count("R12 count");
    check("R12 irq", {7'd0, rx_irq}, 8'h00);

    // R1 / R5 / R7: threshold 4, three bytes
    wr(AC, 8'h03); model_en = 1'b1;
    send(8'hA5, 1'b1); send(8'h3C, 1'b1); send(8'h7E, 1'b1);
    check_count("R1 count after three frames");
    rd(AS, d); check("R7 quiet flag not yet set", d, 8'h10);
    repeat (700) @(negedge clk);
    rd(AS, d); check("R7 quiet flag set", d, 8'h12);

    // R5 / R6: fourth byte reaches threshold
    send(8'h81, 1'b1);
    check("R6 irq at threshold", {7'd0, rx_irq}, 8'h01);
    // R11: write 0 clears only the flag already seen (quiet), not threshold
    wr(AS, 8'h00);
    rd(AS, d); check("R11 unread flag kept", d, 8'h11);
    wr(AS, 8'h01);
    rd(AS, d); check("R11 write 1 no effect", d, 8'h11);
    wr(AS, 8'h00);
    rd(AS, d); check("R11 cleared after read", d, 8'h10);
    check("R6 irq low after clear", {7'd0, rx_irq}, 8'h00);

    // R4: pops in order
    for (int i = 0; i < 4; i++) pop_check("R4 pop order");
    check_count("R4 count empty");

    // R8: framing error, byte kept
    send(8'h55, 1'b0);
    rd(AS, d); check("R8 error no break", d & 8'h0C, 8'h04);
    check_count("R8 byte stored");
    wr(AS, 8'h00);
    pop_check("R8 data");

    // R9 / R10: break
    rx_line = 1'b0;
    repeat (12 * BITCLK) @(negedge clk);
    rd(AS, d); check("R9 R10 break low line", d & 8'h1C, 8'h0C);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    model_q.push_back(8'h00);
    check_count("R9 single byte from break");
    pop_check("R9 break byte");
    wr(AS, 8'h00);
    rd(AS, d); check("R10 line high", d & 8'h10, 8'h10);

    // R3: disabled receiver
    wr(AC, 8'h02); model_en = 1'b0;
    send(8'h99, 1'b1);
    check_count("R3 no store when disabled");

    // R2: glitch start
    wr(AC, 8'h03); model_en = 1'b1;
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    check_count("R2 glitch rejected");

    // R4 / R5: threshold 14, overflow
    wr(AC, 8'h07);
    for (int i = 1; i <= 17; i++) begin
      send(8'(i * 7 + 1), 1'b1);
      if (i == 13) check("R5 below 14", {7'd0, rx_irq}, 8'h00);
      if (i == 14) check("R5 at 14", {7'd0, rx_irq}, 8'h01);
    end
    rd(AN, d); check("R4 full count", d, 8'd16);
    for (int i = 0; i < 16; i++) pop_check("R4 overflow order");
    check_count("R4 drained");

    done = 1'b1;
    report();
  end
endmodule